// File: doc/BRIEF.md
# Frame Region FIFO Feeder

This block sits on the bus of a small processor that drives a video output through a pair of FIFOs. Two equal frame regions are decoded in the address map. While the processor reads bytes from the active region, each byte is written into both video FIFOs in the same cycle. One FIFO serves even scanlines and the other serves odd scanlines, so every byte is fetched only once per frame. The other region acts as plain memory, and the next frame is built there.

A control register chooses which region will be active and sets the video enable. It can also request a FIFO flush. A change of region only takes effect when the video side signals the end of a frame. That signal arrives from another clock domain and is synchronized inside the block. The half-full flags of the two FIFOs drive a refill interrupt. A status register reports the active and pending regions, both half-full states, a busy flush and a sticky underflow flag. The underflow flag is set when a FIFO runs dry while video is running.

Top module: `frame_feed_ctrl`

## Requirements
- R1: A read (`bus_cs`=1, `bus_rd`=1) at offset 0..14999 of the active region asserts `fifo_a_wr` and `fifo_b_wr` together in the same cycle. Region 0 spans 0x0000-0x3FFF and region 1 spans 0x4000-0x7FFF.
- R2: Reads of the inactive region, writes to any address, and reads outside both regions leave both strobes low.
- R3: Reads at window offsets 15000..16383 of the active region leave both strobes low.
- R4: Control bit 0 sets the pending region. The active region takes the pending value only after a rising `frame_end_async`. It is unchanged for the first two clock edges after the rise and has changed by the third edge.
- R5: `irq` is high one clock after both `fifo_a_half_n` and `fifo_b_half_n` are high, and low one clock after either of them is low.
- R6: Writing 1 to control bit 2 drives `fifo_rst` high for 4 cycles, starting after the write edge. Both strobes stay low while `fifo_rst` is high. Bit 2 always reads back as 0.
- R7: At a frame end, video starts running if control bit 1 is set. An empty FIFO while video is running sets status bit 2 and stops the running state. An empty FIFO while video is not running has no effect. Writing 1 to status bit 2 clears it, and writing 0 leaves it unchanged.
- R8: The status register at 0xFF01 reads bit0=active, bit1=pending, bit2=underflow, bit3=FIFO A above half, bit4=FIFO B above half, bit5=flush busy, and 0 in the other bits.
- R9: After reset the active region, the pending region, the enable, the underflow flag, `irq`, `fifo_rst` and both strobes are 0.
- R10: The control register at 0xFF00 reads bit0=pending region and bit1=video enable. `vid_en` follows bit 1. With `bus_cs` low, or at an undecoded address, `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Bus cycle select |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data for the registers |
| fifo_a_half_n | input | 1 | FIFO A half flag, low when above half |
| fifo_b_half_n | input | 1 | FIFO B half flag, low when above half |
| fifo_a_empty | input | 1 | FIFO A empty |
| fifo_b_empty | input | 1 | FIFO B empty |
| frame_end_async | input | 1 | Frame end level from the video clock domain |
| fifo_a_wr | output | 1 | Write strobe for FIFO A |
| fifo_b_wr | output | 1 | Write strobe for FIFO B |
| fifo_rst | output | 1 | Flush of both FIFOs |
| irq | output | 1 | Refill interrupt |
| vid_en | output | 1 | Video enable bit for the video side |
| reg_rdata | output | 8 | Register read data |

## Verification
The bench reads at both ends of the valid range and just past it, at 14999, 15000 and the window end. A decoder with an off-by-one or one that ignores the limit would capture padding bytes into the FIFOs. It holds a status read across the frame-end rise to confirm that the region changes on the third edge and not earlier. A design without the synchronizer, or one that swapped on the register write, would switch too early. It issues active-region reads straight after a flush request; a design that let strobes through during the flush would refill FIFOs that are being cleared. It also checks that a FIFO already empty before video starts does not latch underflow. Finally it checks that a status write of 0 leaves a latched underflow in place.

// File: rtl/vff_pkg.sv
package vff_pkg;
  localparam int unsigned CTRL_PEND = 0;
  localparam int unsigned CTRL_EN   = 1;
  localparam int unsigned CTRL_FRST = 2;

  localparam int unsigned ST_ACT   = 0;
  localparam int unsigned ST_PEND  = 1;
  localparam int unsigned ST_UFL   = 2;
  localparam int unsigned ST_HFA   = 3;
  localparam int unsigned ST_HFB   = 4;
  localparam int unsigned ST_RBUSY = 5;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/vff_edge_sync.sv
module vff_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic pulse_o
);
  logic [SYNC_STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[SYNC_STAGES-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // rising edge seen on the last synchronizer stage
  assign pulse_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/vff_decode.sv
module vff_decode import vff_pkg::*; #(
  parameter int unsigned AW           = 16,
  parameter int unsigned WIN_BITS     = 14,
  parameter logic [AW-WIN_BITS-1:0] FRAME_TOP = '0,
  parameter int unsigned REGION_BYTES = 15000,
  parameter logic [AW-1:0] CTRL_ADDR  = 16'hFF00,
  parameter logic [AW-1:0] STAT_ADDR  = 16'hFF01
) (
  input  logic          bus_cs,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic          active,
  input  logic          block,
  output logic          cap_wr,
  output reg_sel_e      sel
);
  localparam int unsigned TW = AW - WIN_BITS;
  localparam logic [WIN_BITS:0] LIMIT = (WIN_BITS+1)'(REGION_BYTES);

  logic [1:0] in_win;
  logic       off_ok;

  for (genvar k = 0; k < 2; k++) begin : g_win
    localparam logic [TW-1:0] TAG = FRAME_TOP + TW'(k);
    assign in_win[k] = (bus_addr[AW-1:WIN_BITS] == TAG);
  end

  always_comb begin
    off_ok = ({1'b0, bus_addr[WIN_BITS-1:0]} < LIMIT);
    cap_wr = bus_cs & bus_rd & in_win[active] & off_ok & ~block;
    if (bus_addr == CTRL_ADDR)      sel = SEL_CTRL;
    else if (bus_addr == STAT_ADDR) sel = SEL_STAT;
    else                            sel = SEL_NONE;
  end
endmodule

// File: rtl/vff_regs.sv
module vff_regs import vff_pkg::*; #(
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_re,
  input  reg_sel_e   sel,
  input  logic [7:0] wdata,
  input  logic       frame_pulse,
  input  logic       hf_a_n,
  input  logic       hf_b_n,
  input  logic       empty_a,
  input  logic       empty_b,
  output logic       active,
  output logic       vid_en,
  output logic       fifo_rst,
  output logic [7:0] rdata
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);

  logic          pend_q, pend_d, en_q, en_d, act_q, act_d;
  logic          run_q, run_d, ufl_q, ufl_d;
  logic [CW-1:0] rcnt_q, rcnt_d;
  logic          ctrl_we, stat_we, starve, cnt_en;

  always_comb begin
    ctrl_we = reg_we && (sel == SEL_CTRL);
    stat_we = reg_we && (sel == SEL_STAT);
    starve  = run_q && (empty_a || empty_b) && (rcnt_q == '0);
    cnt_en  = (rcnt_q != '0) || (ctrl_we && wdata[CTRL_FRST]);
    pend_d  = pend_q;
    en_d    = en_q;
    act_d   = act_q;
    run_d   = run_q;
    ufl_d   = ufl_q;
    rcnt_d  = rcnt_q;
    if (rcnt_q != '0) rcnt_d = rcnt_q - CW'(1);
    if (ctrl_we) begin
      pend_d = wdata[CTRL_PEND];
      en_d   = wdata[CTRL_EN];
      if (wdata[CTRL_FRST]) rcnt_d = CW'(RST_CYCLES);
    end
    if (frame_pulse) begin
      act_d = pend_q;
      run_d = en_q;
    end
    if (stat_we && wdata[ST_UFL]) ufl_d = 1'b0;
    if (starve) begin
      ufl_d = 1'b1;
      run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      act_q  <= 1'b0;
      run_q  <= 1'b0;
      ufl_q  <= 1'b0;
      rcnt_q <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      act_q  <= act_d;
      run_q  <= run_d;
      ufl_q  <= ufl_d;
      if (cnt_en) rcnt_q <= rcnt_d;
    end
  end

  assign active   = act_q;
  assign vid_en   = en_q;
  assign fifo_rst = (rcnt_q != '0);

  always_comb begin
    rdata = '0;
    if (reg_re) begin
      case (sel)
        SEL_CTRL: begin
          rdata[CTRL_PEND] = pend_q;
          rdata[CTRL_EN]   = en_q;
        end
        SEL_STAT: begin
          rdata[ST_ACT]   = act_q;
          rdata[ST_PEND]  = pend_q;
          rdata[ST_UFL]   = ufl_q;
          rdata[ST_HFA]   = ~hf_a_n;
          rdata[ST_HFB]   = ~hf_b_n;
          rdata[ST_RBUSY] = fifo_rst;
        end
        default: rdata = '0;
      endcase
    end
  end

  // R4: region changes only after a synchronized frame end
  a_r4_swap_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_pulse |=> $stable(act_q));

  // R6: a flush lasts at least two cycles
  a_r6_rst_min_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_rst) |=> fifo_rst);

  // R7: running video with an empty FIFO latches underflow
  a_r7_ufl_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && (empty_a || empty_b) && !fifo_rst) |=> ufl_q);
endmodule

// File: rtl/frame_feed_ctrl.sv
module frame_feed_ctrl import vff_pkg::*; #(
  parameter int unsigned AW           = 16,
  parameter int unsigned WIN_BITS     = 14,
  parameter logic [AW-WIN_BITS-1:0] FRAME_TOP = '0,
  parameter int unsigned REGION_BYTES = 15000,
  parameter logic [AW-1:0] CTRL_ADDR  = 16'hFF00,
  parameter logic [AW-1:0] STAT_ADDR  = 16'hFF01,
  parameter int unsigned RST_CYCLES   = 4,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          fifo_a_half_n,
  input  logic          fifo_b_half_n,
  input  logic          fifo_a_empty,
  input  logic          fifo_b_empty,
  input  logic          frame_end_async,
  output logic          fifo_a_wr,
  output logic          fifo_b_wr,
  output logic          fifo_rst,
  output logic          irq,
  output logic          vid_en,
  output logic [7:0]    reg_rdata
);
  logic     frame_pulse, active, cap_wr, irq_q, irq_d;
  reg_sel_e sel;

  vff_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(frame_end_async), .pulse_o(frame_pulse));

  vff_decode #(
    .AW(AW), .WIN_BITS(WIN_BITS), .FRAME_TOP(FRAME_TOP),
    .REGION_BYTES(REGION_BYTES), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_dec (
    .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_addr(bus_addr), .active(active),
    .block(fifo_rst), .cap_wr(cap_wr), .sel(sel));

  vff_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(bus_cs & ~bus_rd), .reg_re(bus_cs & bus_rd),
    .sel(sel), .wdata(bus_wdata), .frame_pulse(frame_pulse),
    .hf_a_n(fifo_a_half_n), .hf_b_n(fifo_b_half_n),
    .empty_a(fifo_a_empty), .empty_b(fifo_b_empty),
    .active(active), .vid_en(vid_en), .fifo_rst(fifo_rst), .rdata(reg_rdata));

  always_comb irq_d = fifo_a_half_n & fifo_b_half_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq       = irq_q;
  assign fifo_a_wr = cap_wr;
  assign fifo_b_wr = cap_wr;

  // R5: interrupt tracks both half flags one cycle later
  a_r5_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_a_half_n && fifo_b_half_n) |=> irq);
  a_r5_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_a_half_n && fifo_b_half_n) |=> !irq);

  // R6: no capture while the FIFOs are flushed
  a_r6_no_wr_in_rst: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |-> !(fifo_a_wr || fifo_b_wr));

  // R2: writes never capture
  a_r2_no_wr_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && !bus_rd) |-> !(fifo_a_wr || fifo_b_wr));
endmodule

// File: tb/frame_feed_ctrl_tb_top.sv
module frame_feed_ctrl_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, bus_cs, bus_rd, hfa_n, hfb_n, emp_a, emp_b, fe;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, reg_rdata;
  logic        fifo_a_wr, fifo_b_wr, fifo_rst, irq, vid_en;

  localparam logic [15:0] CTRL = 16'hFF00;
  localparam logic [15:0] STAT = 16'hFF01;

  frame_feed_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .fifo_a_half_n(hfa_n), .fifo_b_half_n(hfb_n),
    .fifo_a_empty(emp_a), .fifo_b_empty(emp_b), .frame_end_async(fe),
    .fifo_a_wr(fifo_a_wr), .fifo_b_wr(fifo_b_wr), .fifo_rst(fifo_rst), .irq(irq),
    .vid_en(vid_en), .reg_rdata(reg_rdata));

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    exp_q[$];
  string tag_q[$];
  event  smp_ev;
  logic  last_rst;
  logic [7:0] rv;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares strobes against the queued expectation
  always @(smp_ev) begin
    while (exp_q.size() != 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check((fifo_a_wr == e) && (fifo_b_wr == e), t, {fifo_a_wr, fifo_b_wr}, {e, e});
    end
  end

  task automatic mem_rd(input logic [15:0] a, input bit exp, input string tag);
    @(negedge clk);
    bus_cs = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #2;
    last_rst = fifo_rst;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    -> smp_ev;
    @(posedge clk); #1;
    bus_cs = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d, input bit exp_wr, input string tag);
    @(negedge clk);
    bus_cs = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
    #2;
    exp_q.push_back(exp_wr);
    tag_q.push_back(tag);
    -> smp_ev;
    @(posedge clk); #1;
    bus_cs = 1'b0;
  endtask

  task automatic reg_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #2 d = reg_rdata;
    @(posedge clk); #1;
    bus_cs = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic frame_end();
    @(negedge clk) fe = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) fe = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_cs = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    hfa_n = 1'b1; hfb_n = 1'b1; emp_a = 1'b1; emp_b = 1'b1; fe = 1'b0;
    #12;
    // R9: reset state
    check(!irq && !fifo_rst && !fifo_a_wr && !fifo_b_wr && !vid_en, "R9 reset outputs",
          {irq, fifo_rst, fifo_a_wr, fifo_b_wr, vid_en}, 0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    reg_rd(STAT, rv);
    check(rv == 8'h00, "R9 status after reset (empty FIFOs, video off: R7 no underflow)", rv, 8'h00);
    check(irq == 1'b1, "R5 irq with both below half", irq, 1);

    // R10: idle read data
    #1 check(reg_rdata == 8'h00, "R10 rdata idle", reg_rdata, 0);

    // R1 / R3 / R2 on region 0
    mem_rd(16'h0000, 1'b1, "R1 region0 first byte");
    mem_rd(16'h1234, 1'b1, "R1 region0 middle");
    mem_rd(16'h3A97, 1'b1, "R1 region0 offset 14999");
    mem_rd(16'h3A98, 1'b0, "R3 offset 15000");
    mem_rd(16'h3FFF, 1'b0, "R3 window end");
    mem_rd(16'h4000, 1'b0, "R2 inactive region1");
    mem_rd(16'h8000, 1'b0, "R2 outside windows");
    bus_wr(16'h0010, 8'hAA, 1'b0, "R2 write to active region");

    // R5: irq drops one cycle after a half flag goes low
    @(negedge clk) hfa_n = 1'b0;
    #1 check(irq == 1'b1, "R5 irq before edge", irq, 1);
    @(posedge clk); #2;
    check(irq == 1'b0, "R5 irq after A above half", irq, 0);
    reg_rd(STAT, rv);
    check(rv == 8'h08, "R8 status A above half", rv, 8'h08);
    @(negedge clk) hfa_n = 1'b1; hfb_n = 1'b0;
    reg_rd(STAT, rv);
    check(rv == 8'h10 && irq == 1'b0, "R8 status B above half", rv, 8'h10);
    @(negedge clk) hfb_n = 1'b1;
    @(posedge clk); #2;
    check(irq == 1'b1, "R5 irq back when both below half", irq, 1);

    // R10 / R4: select region 1, pending only
    bus_wr(CTRL, 8'h01, 1'b0, "R2 ctrl write no strobe");
    reg_rd(CTRL, rv);
    check(rv == 8'h01, "R10 ctrl readback", rv, 8'h01);
    reg_rd(STAT, rv);
    check(rv == 8'h02, "R4 pending set, active unchanged", rv, 8'h02);
    mem_rd(16'h4000, 1'b0, "R4 region1 not active yet");

    // R4: swap timing across the frame end rise
    @(negedge clk);
    bus_cs = 1'b1; bus_rd = 1'b1; bus_addr = STAT; fe = 1'b1;
    @(posedge clk); #2;
    check(reg_rdata[0] == 1'b0, "R4 not active after edge 1", reg_rdata[0], 0);
    @(posedge clk); #2;
    check(reg_rdata[0] == 1'b0, "R4 not active after edge 2", reg_rdata[0], 0);
    @(posedge clk); #2;
    check(reg_rdata[0] == 1'b1, "R4 active after edge 3", reg_rdata[0], 1);
    @(negedge clk) bus_cs = 1'b0; bus_rd = 1'b0; fe = 1'b0;
    repeat (2) @(posedge clk);
    mem_rd(16'h4000, 1'b1, "R1 region1 active");
    mem_rd(16'h7A97, 1'b1, "R1 region1 offset 14999");
    mem_rd(16'h7A98, 1'b0, "R3 region1 offset 15000");
    mem_rd(16'h0000, 1'b0, "R2 region0 now inactive");

    // R7: underflow
    @(negedge clk) emp_a = 1'b0; emp_b = 1'b0;
    bus_wr(CTRL, 8'h03, 1'b0, "R7 enable write");
    check(vid_en == 1'b1, "R10 vid_en follows bit1", vid_en, 1);
    frame_end();
    reg_rd(STAT, rv);
    check(rv == 8'h03, "R7 running, no underflow", rv, 8'h03);
    @(negedge clk) emp_b = 1'b1;
    @(negedge clk) emp_b = 1'b0;
    reg_rd(STAT, rv);
    check(rv == 8'h07, "R7 underflow latched", rv, 8'h07);
    bus_wr(STAT, 8'h00, 1'b0, "R7 status write zero");
    reg_rd(STAT, rv);
    check(rv == 8'h07, "R7 write 0 keeps flag", rv, 8'h07);
    bus_wr(STAT, 8'h04, 1'b0, "R7 status write one");
    reg_rd(STAT, rv);
    check(rv == 8'h03, "R7 write 1 clears flag", rv, 8'h03);
    @(negedge clk) emp_a = 1'b1;
    @(negedge clk) emp_a = 1'b0;
    reg_rd(STAT, rv);
    check(rv == 8'h03, "R7 stopped after underflow, no new flag", rv, 8'h03);

    // R6: flush window
    bus_wr(CTRL, 8'h07, 1'b0, "R6 flush write");
    for (int i = 0; i < 5; i++) begin
      mem_rd(16'h4100, (i >= 4), "R6 strobe vs flush");
      check(last_rst == (i < 4), "R6 fifo_rst length", last_rst, (i < 4));
    end
    reg_rd(CTRL, rv);
    check(rv == 8'h03, "R6 flush bit reads 0", rv, 8'h03);

    repeat (2) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule